// File: doc/BRIEF.md
# Multi-Word Entry Queue with Register Access

A hardware FIFO reached through a small register port. Every entry of the queue is a record of one, two or four 32-bit words; the record width is picked by a configuration input. Software pushes a record by writing its words through four aliased word registers, and it pops a record by reading those same registers. A record joins the queue only when its final word is written. It leaves the queue only when its final word is read.

The port accepts one word access per cycle, and `ready_o` completes an access. The word register is selected by `addr_i`, which is the byte offset divided by four. A burst is a run of accepted accesses at increasing word indices. Each stored byte carries an even-parity bit, and every read checks it. When notification is enabled, a failing word produces a two-cycle error response. The master may abandon the rest of its burst after that response.

Top module: `mwq_top`

## Requirements
- R1: After reset `empty_o`=1, `full_o`=0, `resp_err_o`=0.
- R2: `esize_i` encodes the record length: 0 gives 1 word, 1 gives 2 words, 2 or 3 gives 4 words. A record is committed when the word at index length-1 is written, and it holds the most recent data written to each of its word indices.
- R3: A write to the final word while the queue holds DEPTH records is discarded whole. No record is added, and the records already stored are read back unchanged and in order.
- R4: A read while the queue is empty returns 0, completes in the same cycle with no error, and changes no state.
- R5: An access to a word index at or beyond the record length has no effect. A write there is dropped, and a read there returns 0 with no error and no pop.
- R6: Reading words below the final index leaves the record queued. Reading the final word pops it, and records leave in the order they were committed.
- R7: Each byte of a stored word has an even-parity bit. Bit b of `par_flip_i` inverts the stored parity bit of byte b on a write, and this corrupts that word.
- R8: With `par_notify_i`=0, a word with a parity error is returned as it was stored, with `ready_o`=1 and `resp_err_o`=0 in the same cycle.
- R9: With `par_notify_i`=1, a read of a corrupted word answers in two cycles. The first cycle has `ready_o`=0 and `resp_err_o`=1. The second has `ready_o`=1 and `resp_err_o`=1 with the stored word on `rdata_o`. A pop, if the word is final, takes place only on the second cycle.
- R10: Four accesses at word indices 0..3 fill one 4-word record. The same four writes to a 1-word queue commit one record that holds word 0 only.
- R11: `full_o` and `empty_o` are registered and show the record count after each accepted access. `full_o` is set at DEPTH records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| esize_i | input | 2 | Record length code |
| par_notify_i | input | 1 | Enable error response on parity failure |
| req_i | input | 1 | Access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word index (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| par_flip_i | input | 4 | Per-byte parity inversion on write |
| rdata_o | output | 32 | Read data |
| ready_o | output | 1 | Access completes this cycle |
| resp_err_o | output | 1 | Error response |
| full_o | output | 1 | Queue holds DEPTH records |
| empty_o | output | 1 | Queue holds no records |

## Verification
Two functions can fall in the same cycle. The first pair is a pop and a parity error response: the bench reads the final word of a record that was stored with a flipped parity bit while notification is on. It then checks that the record stays queued through the first error cycle and leaves only on the second. The second pair is a commit and overflow: the bench writes a final word into a full queue and judges the outcome by the flags and by reading back every stored record. A behavioural model built on queues predicts the data and the flags, and the flags are compared on every clock.

// File: rtl/mwq_pkg.sv
package mwq_pkg;
  localparam int WORD_W = 32;
  localparam int BYTES  = WORD_W / 8;
  localparam int SWORD_W = WORD_W + BYTES;  // data plus per-byte parity
  localparam int MAX_WORDS = 4;

  typedef logic [SWORD_W-1:0] sword_t;
  typedef enum logic {ACC_IDLE, ACC_ERR2} acc_st_e;

  // index of the final word of a record for a length code
  function automatic logic [1:0] last_idx(input logic [1:0] code);
    unique case (code)
      2'd0:    last_idx = 2'd0;
      2'd1:    last_idx = 2'd1;
      default: last_idx = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/mwq_parity.sv
module mwq_parity #(
  parameter int W = 32
) (
  input  logic [W-1:0]   data_i,
  output logic [W/8-1:0] par_o
);
  localparam int NB = W / 8;
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign par_o[b] = ^data_i[8*b +: 8];  // even parity over byte + bit
  end
endmodule

// File: rtl/mwq_store.sv
module mwq_store #(
  parameter int DEPTH = 16,
  parameter int ENT_W = 144
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [ENT_W-1:0] push_data_i,
  input  logic             pop_i,
  output logic [ENT_W-1:0] head_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full_q, empty_q;

  always_comb begin
    cnt_d = cnt_q;
    if (push_i && !pop_i)      cnt_d = cnt_q + CNT_W'(1);
    else if (pop_i && !push_i) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      full_q   <= 1'b0;
      empty_q  <= 1'b1;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == PTR_MAX) ? '0 : wr_ptr_q + PTR_W'(1);
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == PTR_MAX) ? '0 : rd_ptr_q + PTR_W'(1);
      cnt_q   <= cnt_d;
      full_q  <= (cnt_d == CNT_W'(DEPTH));
      empty_q <= (cnt_d == '0);
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign full_o  = full_q;
  assign empty_o = empty_q;

  a_r3_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r4_no_pop_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r11_full_on_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(DEPTH - 1) && push_i && !pop_i) |=> full_o);
  a_r11_empty_on_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(1) && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/mwq_top.sv
module mwq_top
  import mwq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        esize_i,
  input  logic              par_notify_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [BYTES-1:0]  par_flip_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              resp_err_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int ENT_W = MAX_WORDS * SWORD_W;

  acc_st_e st_q, st_d;
  sword_t  stage_q [MAX_WORDS];
  logic [MAX_WORDS-1:0][SWORD_W-1:0] push_ent, head_ent;
  logic [1:0]       last;
  logic             in_range, acc, wr_acc, rd_acc, rd_valid, err_now;
  logic             push, pop, perr, full, empty;
  logic [BYTES-1:0] wpar, rpar;
  sword_t           wword, hword;

  assign last     = last_idx(esize_i);
  assign in_range = (addr_i <= last);

  // write side: parity generation and record assembly
  mwq_parity #(.W(WORD_W)) u_wpar (.data_i(wdata_i), .par_o(wpar));
  assign wword = {wpar ^ par_flip_i, wdata_i};

  for (genvar k = 0; k < MAX_WORDS; k++) begin : g_asm
    assign push_ent[k] = (addr_i == 2'(k)) ? wword : stage_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MAX_WORDS; k++) stage_q[k] <= '0;
    end else if (wr_acc && in_range) begin
      stage_q[addr_i] <= wword;
    end
  end

  // read side: head word select and parity check
  assign hword = head_ent[addr_i];
  mwq_parity #(.W(WORD_W)) u_rpar (.data_i(hword[WORD_W-1:0]), .par_o(rpar));
  assign perr = (rpar != hword[SWORD_W-1:WORD_W]);

  assign rd_valid = req_i && !we_i && in_range && !empty;
  assign err_now  = rd_valid && par_notify_i && perr;
  assign rdata_o  = rd_valid ? hword[WORD_W-1:0] : '0;

  // access control: normal single-cycle, or two-cycle error response
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ACC_IDLE: if (err_now) st_d = ACC_ERR2;
      ACC_ERR2: st_d = ACC_IDLE;
      default:  st_d = ACC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ACC_IDLE;
    else         st_q <= st_d;
  end

  assign ready_o    = (st_q == ACC_ERR2) ? 1'b1 : !err_now;
  assign resp_err_o = (st_q == ACC_ERR2) ? 1'b1 : err_now;

  assign acc    = req_i && ready_o;
  assign wr_acc = acc && we_i;
  assign rd_acc = acc && !we_i;
  assign push   = wr_acc && in_range && (addr_i == last) && !full;
  assign pop    = rd_acc && rd_valid && (addr_i == last);

  mwq_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_data_i(push_ent),
    .pop_i      (pop),
    .head_o     (head_ent),
    .full_o     (full),
    .empty_o    (empty)
  );

  assign full_o  = full;
  assign empty_o = empty;

  a_r9_err_second_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_err_o && !ready_o) |=> (resp_err_o && ready_o));
  a_r9_no_pop_first_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_err_o && !ready_o) |-> !pop);
  a_r4_underflow_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && empty_o) |-> (rdata_o == '0 && !resp_err_o && ready_o));
  a_r5_beyond_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !in_range) |-> (rdata_o == '0 && !pop));
  a_r5_beyond_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !in_range) |-> !push);
  a_r8_silent_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_notify_i && st_q == ACC_IDLE) |-> (!resp_err_o && ready_o));
  a_r6_pop_final_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |-> (addr_i == last));
endmodule

// File: tb/sim_mwq_top.sv
module sim_mwq_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;

  logic        clk = 0, rst_n = 0;
  logic [1:0]  esize = 0;
  logic        notify = 0, req = 0, we = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  flip = 0;
  logic [31:0] rdata;
  logic        ready, rerr, full, empty;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  logic [127:0] mq[$];
  logic [15:0]  mf[$];
  logic [31:0]  sd[4];
  logic [3:0]   sf[4];

  mwq_top #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .esize_i(esize), .par_notify_i(notify),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .par_flip_i(flip),
    .rdata_o(rdata), .ready_o(ready), .resp_err_o(rerr),
    .full_o(full), .empty_o(empty)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int lastw(input logic [1:0] e);
    return (e == 2'd0) ? 0 : (e == 2'd1) ? 1 : 3;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // R11: flags compared against the model every clock
  always @(negedge clk) if (rst_n && !done) begin
    chk(full == (mq.size() == DEPTH), "R11 full", {31'd0, full}, {31'd0, mq.size() == DEPTH});
    chk(empty == (mq.size() == 0), "R11 empty", {31'd0, empty}, {31'd0, mq.size() == 0});
  end

  task automatic wr(input int w, input logic [31:0] d, input logic [3:0] f);
    int l;
    @(negedge clk);
    req = 1; we = 1; addr = 2'(w); wdata = d; flip = f;
    #1 chk(ready && !rerr, "R2 write ready", {31'd0, ready}, 32'd1);
    @(posedge clk);
    l = lastw(esize);
    if (w <= l) begin
      sd[w] = d; sf[w] = f;
      if (w == l && mq.size() < DEPTH) begin
        mq.push_back({sd[3], sd[2], sd[1], sd[0]});
        mf.push_back({sf[3], sf[2], sf[1], sf[0]});
      end
    end
    #1 req = 0; flip = 0;
  endtask

  task automatic rd(input int w, input string rq);
    int l;
    logic [31:0] exp;
    bit experr, live;
    l = lastw(esize);
    live = (w <= l) && (mq.size() != 0);
    exp = live ? mq[0][32*w +: 32] : 32'd0;
    experr = live && notify && (mf[0][4*w +: 4] != 0);
    @(negedge clk);
    req = 1; we = 0; addr = 2'(w);
    #1;
    if (experr) begin
      chk(!ready && rerr, {rq, " R9 err cycle1"}, {30'd0, ready, rerr}, 32'd1);
      @(posedge clk);
      @(negedge clk); #1;
      chk(ready && rerr, {rq, " R9 err cycle2"}, {30'd0, ready, rerr}, 32'd3);
      chk(rdata == exp, {rq, " R9 data"}, rdata, exp);
    end else begin
      chk(ready && !rerr, {rq, " ready/no err"}, {30'd0, ready, rerr}, 32'd2);
      chk(rdata == exp, {rq, " data"}, rdata, exp);
    end
    @(posedge clk);
    if (live && w == l) begin
      void'(mq.pop_front());
      void'(mf.pop_front());
    end
    #1 req = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin sd[k] = 0; sf[k] = 0; end
    #(CLK_P * 3);
    chk(empty && !full && !rerr, "R1 reset", {29'd0, empty, full, rerr}, 32'd4);
    @(negedge clk) rst_n = 1;

    // R2 R6 R10: 4-word record, burst of four writes, partial reads keep it queued
    esize = 2'd2;
    for (int k = 0; k < 4; k++) wr(k, 32'hA000_0000 + k, 4'h0);
    for (int k = 0; k < 4; k++) wr(k, 32'hB000_0010 + k, 4'h0);
    rd(1, "R6 partial w1");
    rd(0, "R6 partial w0");
    rd(2, "R6 partial w2");
    rd(3, "R6 final w3");
    for (int k = 0; k < 4; k++) rd(k, "R2 second record");
    esize = 2'd3;  // code 3 also 4 words
    for (int k = 0; k < 4; k++) wr(k, 32'hC300_0000 + k, 4'h0);
    for (int k = 0; k < 4; k++) rd(k, "R2 code3");

    // R10 R5: burst into 1-word queue keeps word 0 only
    esize = 2'd0;
    for (int k = 0; k < 4; k++) wr(k, 32'h1111_0000 + k, 4'h0);
    rd(1, "R5 beyond read");
    rd(3, "R5 beyond read");
    rd(0, "R10 one-word record");

    // R4: underflow
    rd(0, "R4 underflow");
    rd(0, "R4 underflow again");

    // R3: fill 2-word queue, then overflow
    esize = 2'd1;
    for (int e = 0; e < DEPTH; e++) begin
      wr(0, 32'h2000_0000 + e, 4'h0);
      wr(1, 32'h2100_0000 + e, 4'h0);
    end
    chk(full, "R3 full after fill", {31'd0, full}, 32'd1);
    wr(0, 32'hDEAD_0000, 4'h0);
    wr(1, 32'hDEAD_0001, 4'h0);
    chk(full, "R3 still full", {31'd0, full}, 32'd1);
    for (int e = 0; e < DEPTH; e++) begin
      rd(0, "R3 readback");
      rd(1, "R3 readback");
    end

    // R7 R8: corrupted word, notification off
    esize = 2'd0; notify = 0;
    wr(0, 32'h5A5A_1234, 4'b0010);
    rd(0, "R8 silent parity");

    // R7 R9: notification on, single word, pop on second cycle
    notify = 1;
    wr(0, 32'h0F0F_F0F0, 4'b1000);
    wr(0, 32'h7777_0001, 4'b0000);
    rd(0, "R9 err final");
    rd(0, "R7 clean word no err");

    // R9: 4-word record with bad word 2; no pop on it, pop on word 3
    esize = 2'd2;
    wr(0, 32'h9000_0000, 4'h0);
    wr(1, 32'h9000_0001, 4'h0);
    wr(2, 32'h9000_0002, 4'b0101);
    wr(3, 32'h9000_0003, 4'b0001);
    rd(2, "R9 err mid");
    rd(0, "R9 still queued");
    rd(3, "R9 err final pop");
    rd(0, "R4 empty after err pop");

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule